// File: doc/BRIEF.md
# Sized Integer ALU Slice with Condition Flags

This block is the execute slice of a 32-bit datapath that operates on byte, word or long operands. Each cycle it may accept one operation, an opcode and a size code, together with a source operand and the current destination contents. One clock later it presents the destination value with the result merged in, a write-back qualifier, and a five-bit condition register. The register is held inside the block, and the opcode selects which of its bits the operation rewrites.

Arithmetic forms cover add, subtract, negate and compare. A quick add or subtract form takes a small immediate. A quick load widens a signed byte to 32 bits. The other forms are move, clear, test, sign extension, half-word swap and the four bitwise operations. Operand fetch, address generation, decode and privilege checks sit outside the block. Any size code that the operation cannot use is refused. The refusal is reported on an error output and nothing changes.

Top module: `sized_alu`

## Requirements
- R1: Encodings. The opcode is MOVE=0, CLR=1, NEG=2, EXT=3, SWAP=4, ADD=5, SUB=6, CMP=7, TST=8, AND=9, OR=10, XOR=11, NOT=12, ADDQ=13, SUBQ=14, MOVEQ=15. The size code is byte=0, word=1, long=2, and 3 is always illegal. The flag vector is {X,N,Z,V,C}, with X at bit 4 and C at bit 0. An operation accepted at a rising edge shows its result, flags, mask and error after that same edge. After reset, the flags, result and error are all zero.
- R2: For byte size only bits 7:0 of the result come from the operation, and for word size only bits 15:0. The remaining bits equal the destination input.
- R3: MOVE (result = source), AND, OR, XOR and NOT (result = inverted destination) write only N and Z. N is the sized MSB and Z means the sized result is zero. X, V and C keep their previous values, and the mask is 01100.
- R4: ADD (dst+src), SUB (dst-src) and NEG (0-dst) write all five flags. C and X both take the carry out of the sized MSB, or the borrow for the subtracting forms. V is signed overflow at that size.
- R5: CLR writes zero to the sized field. It sets Z=1 and N=V=C=0, and X keeps its value.
- R6: CMP forms dst-src at the selected size and writes N, Z, V and C from that difference. X keeps its value, the write-back qualifier is low, and the result output equals the destination input.
- R7: TST sets N and Z from the sized destination, clears V and C, keeps X and does not write back.
- R8: EXT at word size copies bit 7 into bits 15:8. At long size it copies bit 15 into bits 31:16. N and Z are taken from the sized result. EXT at byte size is illegal.
- R9: ADDQ and SUBQ add or subtract the source to or from the destination, with the same flags as ADD and SUB. A source outside 1 to 8 is illegal.
- R10: MOVEQ loads the 32-bit sign extension of source bits 7:0 and writes N and Z. It is legal only at long size.
- R11: SWAP exchanges bits 31:16 and 15:0 of the destination and writes N and Z. It is legal only at long size.
- R12: An illegal combination raises the error output. The result equals the destination, write-back and the mask are low, and all five flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Opcode (see R1) |
| size_i | input | 2 | Size code (see R1) |
| src_i | input | 32 | Source operand or immediate |
| dst_i | input | 32 | Current destination contents |
| valid_o | output | 1 | Outputs below belong to an accepted operation |
| result_o | output | 32 | Destination with sized result merged |
| wb_o | output | 1 | Result is to be written back |
| flags_o | output | 5 | Condition register {X,N,Z,V,C} |
| fmask_o | output | 5 | Flags rewritten by the last operation |
| err_o | output | 1 | Last operation was an illegal combination |

## Verification
The directed cases target the edges of the sized carry and overflow logic. A signed byte overflow that produces no carry checks that V is taken at the selected MSB: a design that used bit 31 instead would report it clear. A word add that wraps to zero checks Z and C, and a borrow from zero checks the subtract path. Other cases check that the negate of the most negative byte overflows, and that the upper bytes survive a byte clear. Some cases must be refused: quick immediates of 0 and 9, byte-size extension, and size code 3. For these a design that still acted would change the flags or the result. Random operations then run against the flag register carried by the bench, which exposes any flag that an operation rewrites without a right to it.

// File: rtl/alu_pkg.sv
// Shared types and helpers for the sized ALU slice.
// Assumes a 32-bit datapath built from byte lanes.
package alu_pkg;
    localparam int XLEN   = 32;
    localparam int FLAG_W = 5;
    localparam int LANE_W = 8;
    localparam int LANES  = XLEN / LANE_W;
    localparam int QMIN   = 1;
    localparam int QMAX   = 8;

    localparam int FX = 4;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FV = 1;
    localparam int FC = 0;

    localparam logic [FLAG_W-1:0] MASK_NZ   = 5'b01100;
    localparam logic [FLAG_W-1:0] MASK_NZVC = 5'b01111;
    localparam logic [FLAG_W-1:0] MASK_ALL  = 5'b11111;

    typedef enum logic [3:0] {
        OP_MOVE  = 4'd0,  OP_CLR  = 4'd1,  OP_NEG  = 4'd2,  OP_EXT   = 4'd3,
        OP_SWAP  = 4'd4,  OP_ADD  = 4'd5,  OP_SUB  = 4'd6,  OP_CMP   = 4'd7,
        OP_TST   = 4'd8,  OP_AND  = 4'd9,  OP_OR   = 4'd10, OP_XOR   = 4'd11,
        OP_NOT   = 4'd12, OP_ADDQ = 4'd13, OP_SUBQ = 4'd14, OP_MOVEQ = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2, SZ_BAD = 2'd3
    } size_e;

    // Most significant bit of a value at the given size.
    function automatic logic sz_msb(input size_e sz, input logic [XLEN-1:0] v);
        case (sz)
            SZ_B:    return v[7];
            SZ_W:    return v[15];
            default: return v[31];
        endcase
    endfunction

    // True when the sized field of a value is all zero.
    function automatic logic sz_zero(input size_e sz, input logic [XLEN-1:0] v);
        case (sz)
            SZ_B:    return v[7:0] == '0;
            SZ_W:    return v[15:0] == '0;
            default: return v == '0;
        endcase
    endfunction
endpackage

// File: rtl/alu_arith.sv
// Sized adder/subtractor. Computes a+b or a-b and reports the carry (or the
// borrow) and the signed overflow at the MSB of the selected size.
// Assumes the caller selects operands; size code 3 falls back to long.
module alu_arith
    import alu_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    input  size_e           size_i,
    output logic [XLEN-1:0] sum_o,
    output logic            carry_o,
    output logic            ovf_o
);
    localparam int NSZ = 3;

    logic [XLEN-1:0] bx;
    logic [NSZ-1:0]  cy;
    logic [NSZ-1:0]  ov;

    // Invert the second operand when subtracting (a + ~b + 1).
    assign bx    = sub_i ? ~b_i : b_i;
    assign sum_o = a_i + bx + {{(XLEN-1){1'b0}}, sub_i};

    // One carry and overflow tap for each operand size.
    for (genvar g = 0; g < NSZ; g++) begin : g_size
        localparam int W = LANE_W << g;
        logic [W:0] s;
        assign s     = {1'b0, a_i[W-1:0]} + {1'b0, bx[W-1:0]} + {{W{1'b0}}, sub_i};
        assign cy[g] = s[W] ^ sub_i;
        assign ov[g] = (a_i[W-1] == bx[W-1]) && (s[W-1] != a_i[W-1]);
    end

    // Pick the tap for the requested size.
    always_comb begin
        case (size_i)
            SZ_B:    begin carry_o = cy[0]; ovf_o = ov[0]; end
            SZ_W:    begin carry_o = cy[1]; ovf_o = ov[1]; end
            default: begin carry_o = cy[2]; ovf_o = ov[2]; end
        endcase
    end
endmodule

// File: rtl/alu_shape.sv
// Result former: produces the raw 32-bit value of each operation before the
// sized merge. Arithmetic results arrive already computed on sum_i.
module alu_shape
    import alu_pkg::*;
(
    input  op_e             op_i,
    input  size_e           size_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] dst_i,
    input  logic [XLEN-1:0] sum_i,
    output logic [XLEN-1:0] raw_o
);
    localparam int HALF = XLEN / 2;

    // Select the raw value by opcode.
    always_comb begin
        case (op_i)
            OP_MOVE:  raw_o = src_i;
            OP_CLR:   raw_o = '0;
            OP_EXT:   raw_o = (size_i == SZ_W)
                            ? {dst_i[XLEN-1:HALF], {LANE_W{dst_i[LANE_W-1]}}, dst_i[LANE_W-1:0]}
                            : {{HALF{dst_i[HALF-1]}}, dst_i[HALF-1:0]};
            OP_SWAP:  raw_o = {dst_i[HALF-1:0], dst_i[XLEN-1:HALF]};
            OP_TST:   raw_o = dst_i;
            OP_AND:   raw_o = src_i & dst_i;
            OP_OR:    raw_o = src_i | dst_i;
            OP_XOR:   raw_o = src_i ^ dst_i;
            OP_NOT:   raw_o = ~dst_i;
            OP_MOVEQ: raw_o = {{(XLEN-LANE_W){src_i[LANE_W-1]}}, src_i[LANE_W-1:0]};
            default:  raw_o = sum_i;
        endcase
    end
endmodule

// File: rtl/alu_merge.sv
// Sized lane merge: low lanes covered by the size take the new value, the
// upper lanes keep the old destination contents.
module alu_merge
    import alu_pkg::*;
(
    input  size_e           size_i,
    input  logic [XLEN-1:0] keep_i,
    input  logic [XLEN-1:0] new_i,
    output logic [XLEN-1:0] out_o
);
    localparam int CW = $clog2(LANES) + 1;

    logic [CW-1:0] act;

    // Number of byte lanes the size covers.
    always_comb begin
        case (size_i)
            SZ_B:    act = CW'(1);
            SZ_W:    act = CW'(2);
            default: act = CW'(LANES);
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign out_o[g*LANE_W +: LANE_W] = (CW'(g) < act) ? new_i[g*LANE_W +: LANE_W]
                                                          : keep_i[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/sized_alu.sv
// Top of the sized ALU slice. Checks legality, forms the result and the new
// flags, and registers result, write-back, flags, mask and error one cycle
// after an accepted operation. The condition register lives here.
// Assumes the operands are already fetched; synchronous active-low reset.
module sized_alu
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [XLEN-1:0]   src_i,
    input  logic [XLEN-1:0]   dst_i,
    output logic              valid_o,
    output logic [XLEN-1:0]   result_o,
    output logic              wb_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] fmask_o,
    output logic              err_o
);
    op_e               op;
    size_e             sz;
    logic              illegal;
    logic              is_arith;
    logic              is_sub;
    logic              no_wb;
    logic [XLEN-1:0]   a_op;
    logic [XLEN-1:0]   b_op;
    logic [XLEN-1:0]   sum;
    logic              carry;
    logic              ovf;
    logic [XLEN-1:0]   raw;
    logic [XLEN-1:0]   merged;
    logic [FLAG_W-1:0] new_f;
    logic [FLAG_W-1:0] mask;

    assign op = op_e'(op_i);
    assign sz = size_e'(size_i);

    // Legality of the opcode and size pairing.
    always_comb begin
        illegal = (sz == SZ_BAD);
        case (op)
            OP_EXT:            if (sz == SZ_B) illegal = 1'b1;
            OP_SWAP, OP_MOVEQ: if (sz != SZ_L) illegal = 1'b1;
            OP_ADDQ, OP_SUBQ:  if (src_i < XLEN'(QMIN) || src_i > XLEN'(QMAX)) illegal = 1'b1;
            default: ;
        endcase
    end

    // Operand steering for the adder.
    always_comb begin
        is_arith = op inside {OP_NEG, OP_ADD, OP_SUB, OP_CMP, OP_ADDQ, OP_SUBQ};
        is_sub   = op inside {OP_NEG, OP_SUB, OP_CMP, OP_SUBQ};
        no_wb    = op inside {OP_CMP, OP_TST};
        a_op     = (op == OP_NEG) ? '0 : dst_i;
        b_op     = (op == OP_NEG) ? dst_i : src_i;
    end

    alu_arith u_arith (
        .a_i     (a_op),
        .b_i     (b_op),
        .sub_i   (is_sub),
        .size_i  (sz),
        .sum_o   (sum),
        .carry_o (carry),
        .ovf_o   (ovf)
    );

    alu_shape u_shape (
        .op_i   (op),
        .size_i (sz),
        .src_i  (src_i),
        .dst_i  (dst_i),
        .sum_i  (sum),
        .raw_o  (raw)
    );

    alu_merge u_merge (
        .size_i (sz),
        .keep_i (dst_i),
        .new_i  (raw),
        .out_o  (merged)
    );

    // Candidate flag values and the mask of flags this opcode may rewrite.
    always_comb begin
        new_f     = '0;
        new_f[FX] = carry;
        new_f[FN] = sz_msb(sz, raw);
        new_f[FZ] = sz_zero(sz, raw);
        new_f[FV] = is_arith & ovf;
        new_f[FC] = is_arith & carry;
        case (op)
            OP_NEG, OP_ADD, OP_SUB, OP_ADDQ, OP_SUBQ: mask = MASK_ALL;
            OP_CMP, OP_CLR, OP_TST:                   mask = MASK_NZVC;
            default:                                  mask = MASK_NZ;
        endcase
    end

    // Register the outcome of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            result_o <= '0;
            wb_o     <= 1'b0;
            flags_o  <= '0;
            fmask_o  <= '0;
            err_o    <= 1'b0;
        end else begin
            valid_o <= valid_i;
            wb_o    <= valid_i & ~illegal & ~no_wb;
            err_o   <= valid_i & illegal;
            if (valid_i) begin
                result_o <= (illegal || no_wb) ? dst_i : merged;
                fmask_o  <= illegal ? '0 : mask;
                if (!illegal) flags_o <= (flags_o & ~mask) | (new_f & mask);
            end
        end
    end

    // R2
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && $past(size_i) == SZ_B |-> result_o[XLEN-1:LANE_W] == $past(dst_i[XLEN-1:LANE_W]));

    // R3
    masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((flags_o ^ $past(flags_o)) & ~fmask_o) == '0);

    // R5
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !err_o && $past(op_i) == OP_CLR |->
            flags_o[3:0] == 4'b0100 && flags_o[FX] == $past(flags_o[FX]));

    // R6
    cmp_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && $past(op_i) == OP_CMP |-> !wb_o && result_o == $past(dst_i));

    // R9
    quick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && $past(op_i) == OP_ADDQ && $past(src_i) == '0 |-> err_o);

    // R12
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && err_o |-> $stable(flags_o) && !wb_o && result_o == $past(dst_i));
endmodule

// File: tb/test_sized_alu.sv
module test_sized_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic        valid_o;
    logic [31:0] result_o;
    logic        wb_o;
    logic [4:0]  flags_o;
    logic [4:0]  fmask_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] exp_flags = '0;

    always #2.5 clk = ~clk;

    sized_alu i_sized_alu (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
        .src_i(src_i), .dst_i(dst_i), .valid_o(valid_o), .result_o(result_o),
        .wb_o(wb_o), .flags_o(flags_o), .fmask_o(fmask_o), .err_o(err_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd9, 4'd10, 4'd11, 4'd12: return "R3";
            4'd1:  return "R5";
            4'd2, 4'd5, 4'd6: return "R4";
            4'd3:  return "R8";
            4'd4:  return "R11";
            4'd7:  return "R6";
            4'd8:  return "R7";
            4'd15: return "R10";
            default: return "R9";
        endcase
    endfunction

    // Reference: sized arithmetic through wide compare and subtract.
    function automatic void model(input logic [3:0] op, input logic [1:0] sz,
                                  input logic [31:0] s, input logic [31:0] d,
                                  input logic [4:0] fl, output logic [31:0] r,
                                  output logic [4:0] nf, output logic e, output logic w);
        int W;
        logic [63:0] m, a, b, t, low;
        logic n, z, c, v, sa, sb, st;
        logic [4:0] mk;
        e = (sz == 2'd3);
        if (op == 4'd3 && sz == 2'd0) e = 1'b1;
        if ((op == 4'd4 || op == 4'd15) && sz != 2'd2) e = 1'b1;
        if ((op == 4'd13 || op == 4'd14) && (s < 1 || s > 8)) e = 1'b1;
        W = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m = (64'd1 << W) - 1;
        a = {32'd0, d} & m;
        b = {32'd0, s} & m;
        c = 1'b0; v = 1'b0;
        mk = 5'b01100;
        case (op)
            4'd0:  t = b;
            4'd1:  begin t = 0; mk = 5'b01111; end
            4'd3:  t = (sz == 2'd1) ? (d[7] ? 64'hFF00 | d[7:0] : {56'd0, d[7:0]})
                                    : (d[15] ? 64'hFFFF0000 | d[15:0] : {48'd0, d[15:0]});
            4'd4:  t = {32'd0, d[15:0], d[31:16]};
            4'd8:  begin t = a; mk = 5'b01111; end
            4'd9:  t = a & b;
            4'd10: t = a | b;
            4'd11: t = a ^ b;
            4'd12: t = ~a & m;
            4'd15: t = {32'd0, {24{s[7]}}, s[7:0]};
            4'd5, 4'd13: begin
                t = a + b; c = t[W]; mk = 5'b11111;
                sa = a[W-1]; sb = b[W-1]; st = t[W-1];
                v = (sa == sb) && (st != sa);
            end
            default: begin
                if (op == 4'd2) begin a = 0; b = {32'd0, d} & m; end
                t = a - b; c = (a < b);
                mk = (op == 4'd7) ? 5'b01111 : 5'b11111;
                sa = a[W-1]; sb = b[W-1]; st = t[W-1];
                v = (sa != sb) && (st != sa);
            end
        endcase
        low = t & m;
        n = low[W-1];
        z = (low == 0);
        if (e) begin
            r = d; nf = fl; w = 1'b0;
        end else begin
            w = !(op == 4'd7 || op == 4'd8);
            r = w ? ((d & ~m[31:0]) | low[31:0]) : d;
            nf = (fl & ~mk) | ({c, n, z, v, c} & mk);
        end
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic [1:0] sz,
                         input logic [31:0] s, input logic [31:0] d);
        logic [31:0] er; logic [4:0] ef; logic ee, ew;
        string rq;
        model(op, sz, s, d, exp_flags, er, ef, ee, ew);
        rq = ee ? "R12" : req_of(op);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; size_i = sz; src_i = s; dst_i = d;
        @(negedge clk);
        valid_i = 1'b0;
        check("R1", "valid", {31'd0, valid_o}, 32'd1);
        check(rq, "result", result_o, er);
        check(rq, "flags", {27'd0, flags_o}, {27'd0, ef});
        check(rq, "err", {31'd0, err_o}, {31'd0, ee});
        check(rq, "wb", {31'd0, wb_o}, {31'd0, ew});
        exp_flags = ef;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset flags", {27'd0, flags_o}, 32'd0);
        check("R1", "reset err", {31'd0, err_o}, 32'd0);
        check("R1", "reset result", result_o, 32'd0);

        // R4 byte add signed overflow without carry
        do_op(4'd5, 2'd0, 32'h01, 32'hAAAA_AA7F);
        // R4 word add wraps to zero with carry
        do_op(4'd5, 2'd1, 32'h0001, 32'h1234_FFFF);
        // R4 long subtract borrow from zero
        do_op(4'd6, 2'd2, 32'h1, 32'h0);
        // R4 negate most negative byte
        do_op(4'd2, 2'd0, 32'h0, 32'h5555_5580);
        // R6 compare equal and less
        do_op(4'd7, 2'd1, 32'h0003, 32'h0003);
        do_op(4'd7, 2'd0, 32'h62, 32'h02);
        // R7 test negative word
        do_op(4'd8, 2'd1, 32'h0, 32'h0000_8000);
        // R5 byte clear keeps upper bytes, R2
        do_op(4'd1, 2'd0, 32'h0, 32'h0000_F776);
        // R8 sign extension both sizes and illegal byte
        do_op(4'd3, 2'd1, 32'h0, 32'hABCD_0080);
        do_op(4'd3, 2'd2, 32'h0, 32'h0000_8001);
        do_op(4'd3, 2'd0, 32'h0, 32'h0000_0080);
        // R11 swap
        do_op(4'd4, 2'd2, 32'h0, 32'hFFFF_0000);
        // R10 quick load
        do_op(4'd15, 2'd2, 32'h80, 32'h1234_5678);
        do_op(4'd15, 2'd1, 32'h05, 32'h1234_5678);
        // R9 quick immediate limits
        do_op(4'd13, 2'd1, 32'd8, 32'h0000_FFF9);
        do_op(4'd14, 2'd0, 32'd1, 32'h0000_0000);
        do_op(4'd13, 2'd2, 32'd0, 32'h10);
        do_op(4'd14, 2'd2, 32'd9, 32'h10);
        // R12 size code 3
        do_op(4'd5, 2'd3, 32'h1, 32'h1);
        // R3 logic ops keep X, V, C
        do_op(4'd11, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_op(4'd12, 2'd1, 32'h0, 32'h0000_00FF);

        for (int k = 0; k < 800; k++) begin
            logic [3:0] op; logic [1:0] sz; logic [31:0] s, d;
            op = 4'($urandom_range(0, 15));
            sz = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            s  = $urandom;
            d  = $urandom;
            if (op == 4'd13 || op == 4'd14) s = $urandom_range(0, 10);
            if ($urandom_range(0, 7) == 0) d = 32'h0000_0080 << $urandom_range(0, 24);
            do_op(op, sz, s, d);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule